// File: doc/BRIEF.md
# Horizontal-Reuse Search Window Buffer

This block holds the reference search window that a motion estimator scans for each current block. Current blocks are N×N pixels and the search range is [-P, +P-1], so the window is 2P+N-1 pixels on each side. Blocks are handled strictly left to right along one block row. Horizontally adjacent blocks share all but N of their window columns, so the buffer keeps the shared columns in place and fetches only the N columns that enter on the right.

Columns are stored in a ring whose size is the window width. A head pointer gives the physical column that holds window column 0. Each advance moves the head by N, modulo the ring size. A row-start command reloads the whole window and sets the head to zero. An advance command loads N new columns into the slots of the N oldest ones. Pixels are requested one at a time, column by column, top to bottom. The read port takes a window-relative (x, y) and returns that pixel one clock later. The address translation through the head pointer is hidden from the reader.

With the default sizes, N=4 and P=4 give an 11×11 window. Averaged over a row, each reference pixel is brought on chip about 2P/N+1 times.

Top module: `search_win_buf`

## Requirements
- R1: While reset is high and in the cycle after it, `win_ready` and `fetch_req` are both 0.
- R2: A `row_start` pulse starts a full load of WIN_W×WIN_H pixels (WIN_W = WIN_H = 2P+N-1). The requests run through window columns x = 0 to WIN_W-1. Within each column they run through rows y = 0 to WIN_H-1. The first request (x=0, y=0) is presented in the cycle after the pulse.
- R3: A `blk_next` pulse while `win_ready` is 1 starts a load of exactly N×WIN_H pixels. Those pixels fill window columns x = WIN_W-N to WIN_W-1, with the same top-to-bottom order. The first request (x=WIN_W-N, y=0) is presented in the cycle after the pulse. All other columns are kept.
- R4: `win_ready` falls in the cycle after a load starts. It stays 0 while requests are pending and rises in the cycle after the last pixel is accepted. `win_ready` and `fetch_req` are never 1 together.
- R5: One cycle after (`rd_x`, `rd_y`) are applied, `rd_pix` equals the reference pixel at absolute column k·N + `rd_x`, row `rd_y`. Here k is the number of accepted `blk_next` commands since the last `row_start`. Inputs must satisfy `rd_x` < WIN_W and `rd_y` < WIN_H.
- R6: `blk_next` is ignored while `win_ready` is 0, both during a load and before the first load. The request count and the stored window are unchanged.
- R7: `row_start` takes effect at any time, including in the middle of a load. It restarts a full load and resets the block count k to 0.
- R8: A pixel is accepted only in a cycle where `fetch_req` and `fetch_vld` are both 1. While a request is not accepted, `fetch_x` and `fetch_y` hold their values.
- R9: Reads stay correct after the head pointer has wrapped past the end of the ring several times within a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_start | input | 1 | Pulse: begin a new block row with a full window load |
| blk_next | input | 1 | Pulse: step to the next block and load N new columns |
| fetch_req | output | 1 | A pixel is requested from external memory |
| fetch_x | output | $clog2(WIN_W) | Window-relative column of the requested pixel |
| fetch_y | output | $clog2(WIN_H) | Row of the requested pixel |
| fetch_vld | input | 1 | External memory presents `fetch_pix` for the current request |
| fetch_pix | input | PIX_W | Requested pixel value |
| rd_x | input | $clog2(WIN_W) | Window-relative read column |
| rd_y | input | $clog2(WIN_H) | Read row |
| rd_pix | output | PIX_W | Pixel at (`rd_x`, `rd_y`), one cycle later |
| win_ready | output | 1 | The window is complete and may be read |

## Verification
The checker watches the request side on every cycle. It checks the following:
- the starting coordinates after each kind of command;
- the top-to-bottom stepping of `fetch_y`;
- the hold of the request coordinates under back-pressure;
- that `win_ready` and `fetch_req` are never high together;
- that an early `blk_next` is dropped.

Only the bench scenarios show whether the stored pixels are correct. These cover several things that a per-cycle property cannot:
- the total number of accepted pixels for each command;
- that the reused columns survive an advance;
- the circular address translation after the head has wrapped;
- a restart in the middle of a load.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_state_t;

  function automatic int win_span(input int blk_n, input int range_p);
    return 2 * range_p + blk_n - 1;
  endfunction

endpackage

// File: rtl/swb_addr_map.sv
module swb_addr_map #(
  parameter int COLS = 11,
  parameter int ROWS = 11,
  parameter int XW   = 4,
  parameter int YW   = 4,
  parameter int AW   = 7
) (
  input  logic [XW-1:0] win_x,
  input  logic [XW-1:0] head,
  input  logic [YW-1:0] win_y,
  output logic [AW-1:0] addr
);
  localparam int SW = XW + 1;

  logic [SW-1:0] sum;
  logic [XW-1:0] phys;

  always_comb begin
    sum = {1'b0, win_x} + {1'b0, head};
    if (sum >= SW'(COLS)) phys = XW'(sum - SW'(COLS));
    else                  phys = XW'(sum);
    addr = AW'(phys) * AW'(ROWS) + AW'(win_y);
  end

endmodule

// File: rtl/swb_col_ram.sv
module swb_col_ram #(
  parameter int DEPTH = 121,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/swb_fill_ctrl.sv
module swb_fill_ctrl
  import swb_pkg::*;
#(
  parameter int COLS  = 11,
  parameter int ROWS  = 11,
  parameter int STEP  = 4,
  parameter int XW    = 4,
  parameter int YW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          row_start,
  input  logic          blk_next,
  input  logic          fetch_vld,
  output logic          fetch_req,
  output logic [XW-1:0] fetch_x,
  output logic [YW-1:0] fetch_y,
  output logic [XW-1:0] head,
  output logic          win_ready,
  output logic          wr_en
);
  localparam logic [XW-1:0] X_LAST    = XW'(COLS - 1);
  localparam logic [XW-1:0] X_NEWCOL  = XW'(COLS - STEP);
  localparam logic [YW-1:0] Y_LAST    = YW'(ROWS - 1);
  localparam int            HW        = XW + 1;

  fill_state_t   state;
  logic [HW-1:0] head_sum;
  logic [XW-1:0] head_adv;

  always_comb begin
    head_sum = {1'b0, head} + HW'(STEP);
    if (head_sum >= HW'(COLS)) head_adv = XW'(head_sum - HW'(COLS));
    else                       head_adv = XW'(head_sum);
  end

  assign fetch_req = (state == FS_FILL);
  assign wr_en     = fetch_req && fetch_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FS_IDLE;
      win_ready <= 1'b0;
      head      <= '0;
      fetch_x   <= '0;
      fetch_y   <= '0;
    end else if (row_start) begin
      state     <= FS_FILL;
      win_ready <= 1'b0;
      head      <= '0;
      fetch_x   <= '0;
      fetch_y   <= '0;
    end else if (blk_next && win_ready) begin
      state     <= FS_FILL;
      win_ready <= 1'b0;
      head      <= head_adv;
      fetch_x   <= X_NEWCOL;
      fetch_y   <= '0;
    end else if (wr_en) begin
      if (fetch_y == Y_LAST) begin
        fetch_y <= '0;
        if (fetch_x == X_LAST) begin
          state     <= FS_IDLE;
          win_ready <= 1'b1;
        end else begin
          fetch_x <= fetch_x + 1'b1;
        end
      end else begin
        fetch_y <= fetch_y + 1'b1;
      end
    end
  end

endmodule

// File: rtl/search_win_buf.sv
module search_win_buf
  import swb_pkg::*;
#(
  parameter int BLK_N   = 4,
  parameter int RANGE_P = 4,
  parameter int PIX_W   = 8
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       row_start,
  input  logic                                       blk_next,
  output logic                                       fetch_req,
  output logic [$clog2(2*RANGE_P+BLK_N-1)-1:0]       fetch_x,
  output logic [$clog2(2*RANGE_P+BLK_N-1)-1:0]       fetch_y,
  input  logic                                       fetch_vld,
  input  logic [PIX_W-1:0]                           fetch_pix,
  input  logic [$clog2(2*RANGE_P+BLK_N-1)-1:0]       rd_x,
  input  logic [$clog2(2*RANGE_P+BLK_N-1)-1:0]       rd_y,
  output logic [PIX_W-1:0]                           rd_pix,
  output logic                                       win_ready
);
  localparam int WIN_W = win_span(BLK_N, RANGE_P);
  localparam int WIN_H = win_span(BLK_N, RANGE_P);
  localparam int XW    = $clog2(WIN_W);
  localparam int YW    = $clog2(WIN_H);
  localparam int DEPTH = WIN_W * WIN_H;
  localparam int AW    = $clog2(DEPTH);

  logic [XW-1:0] head;
  logic          wr_en;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;

  swb_fill_ctrl #(
    .COLS(WIN_W), .ROWS(WIN_H), .STEP(BLK_N), .XW(XW), .YW(YW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .row_start(row_start), .blk_next(blk_next),
    .fetch_vld(fetch_vld), .fetch_req(fetch_req), .fetch_x(fetch_x),
    .fetch_y(fetch_y), .head(head), .win_ready(win_ready), .wr_en(wr_en)
  );

  swb_addr_map #(
    .COLS(WIN_W), .ROWS(WIN_H), .XW(XW), .YW(YW), .AW(AW)
  ) u_wmap (
    .win_x(fetch_x), .head(head), .win_y(fetch_y), .addr(waddr)
  );

  swb_addr_map #(
    .COLS(WIN_W), .ROWS(WIN_H), .XW(XW), .YW(YW), .AW(AW)
  ) u_rmap (
    .win_x(rd_x), .head(head), .win_y(rd_y), .addr(raddr)
  );

  swb_col_ram #(
    .DEPTH(DEPTH), .AW(AW), .DW(PIX_W)
  ) u_ram (
    .clk(clk), .we(wr_en), .waddr(waddr), .wdata(fetch_pix),
    .raddr(raddr), .rdata(rd_pix)
  );

endmodule

// File: rtl/search_win_buf_chk.sv
module search_win_buf_chk #(
  parameter int BLK_N   = 4,
  parameter int RANGE_P = 4
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 row_start,
  input logic                                 blk_next,
  input logic                                 fetch_req,
  input logic [$clog2(2*RANGE_P+BLK_N-1)-1:0] fetch_x,
  input logic [$clog2(2*RANGE_P+BLK_N-1)-1:0] fetch_y,
  input logic                                 fetch_vld,
  input logic                                 win_ready
);
  localparam int WIN_W = 2 * RANGE_P + BLK_N - 1;
  localparam int XW    = $clog2(WIN_W);
  localparam logic [XW-1:0] X_NEWCOL = XW'(WIN_W - BLK_N);
  localparam logic [XW-1:0] Y_LAST   = XW'(WIN_W - 1);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!win_ready && !fetch_req));

  a_r4_ready_excl: assert property (@(posedge clk) disable iff (rst)
    !(win_ready && fetch_req));

  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    row_start |=> (fetch_req && fetch_x == '0 && fetch_y == '0 && !win_ready));

  a_r3_advance_start: assert property (@(posedge clk) disable iff (rst)
    (win_ready && blk_next && !row_start) |=>
      (fetch_req && fetch_x == X_NEWCOL && fetch_y == '0));

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !fetch_vld && !row_start) |=>
      ($stable(fetch_x) && $stable(fetch_y) && fetch_req));

  a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_vld && !row_start && fetch_y != Y_LAST) |=>
      (fetch_y == $past(fetch_y) + 1'b1 && $stable(fetch_x)));

  a_r6_early_advance: assert property (@(posedge clk) disable iff (rst)
    (blk_next && !win_ready && !fetch_req && !row_start) |=> !fetch_req);

endmodule

bind search_win_buf search_win_buf_chk #(
  .BLK_N(BLK_N), .RANGE_P(RANGE_P)
) u_chk (
  .clk(clk), .rst(rst), .row_start(row_start), .blk_next(blk_next),
  .fetch_req(fetch_req), .fetch_x(fetch_x), .fetch_y(fetch_y),
  .fetch_vld(fetch_vld), .win_ready(win_ready)
);

// File: tb/search_win_buf_bench.sv
module search_win_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int P  = 4;
  localparam int PW = 8;
  localparam int W  = 2 * P + N - 1;
  localparam int XW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          row_start = 1'b0;
  logic          blk_next  = 1'b0;
  logic          fetch_req;
  logic [XW-1:0] fetch_x, fetch_y;
  logic          fetch_vld = 1'b0;
  logic [PW-1:0] fetch_pix = '0;
  logic [XW-1:0] rd_x = '0, rd_y = '0;
  logic [PW-1:0] rd_pix;
  logic          win_ready;

  int errors = 0;
  int checks = 0;
  int row_id = 0;
  int base   = 0;
  bit inject_adv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  search_win_buf #(.BLK_N(N), .RANGE_P(P), .PIX_W(PW)) u_search_win_buf (
    .clk(clk), .rst(rst), .row_start(row_start), .blk_next(blk_next),
    .fetch_req(fetch_req), .fetch_x(fetch_x), .fetch_y(fetch_y),
    .fetch_vld(fetch_vld), .fetch_pix(fetch_pix), .rd_x(rd_x), .rd_y(rd_y),
    .rd_pix(rd_pix), .win_ready(win_ready)
  );

  function automatic logic [PW-1:0] ref_pix(input int rid, input int col, input int y);
    return PW'((col * 37 + y * 11 + rid * 101 + 3) ^ (col >> 3));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_row();
    @(negedge clk); row_start = 1'b1;
    @(negedge clk); row_start = 1'b0;
    base = 0;
    check(fetch_req && fetch_x == 0 && fetch_y == 0, "R2", int'(fetch_x), 0);
    check(!win_ready, "R4", int'(win_ready), 0);
  endtask

  task automatic pulse_blk();
    @(negedge clk); blk_next = 1'b1;
    @(negedge clk); blk_next = 1'b0;
    base += N;
    check(fetch_req && fetch_x == XW'(W - N) && fetch_y == 0, "R3",
          int'(fetch_x), W - N);
    check(!win_ready, "R4", int'(win_ready), 0);
  endtask

  // Serve requests; stop_after > 0 aborts after that many beats.
  task automatic serve(input int exp_beats, input int x0, input int stop_after,
                       input string req);
    int beats = 0, ex = x0, ey = 0, bad_ord = 0, bad_rdy = 0;
    bit vld;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      blk_next = inject_adv && (cyc == 3);
      if (!fetch_req || (stop_after > 0 && beats == stop_after)) break;
      if (int'(fetch_x) != ex || int'(fetch_y) != ey) bad_ord++;
      if (win_ready) bad_rdy++;
      vld = ($urandom % 4) != 0;
      fetch_vld = vld;
      fetch_pix = ref_pix(row_id, base + int'(fetch_x), int'(fetch_y));
      if (vld) begin
        beats++; ey++;
        if (ey == W) begin ey = 0; ex++; end
      end
    end
    fetch_vld = 1'b0;
    blk_next  = 1'b0;
    check(bad_ord == 0, "R8 order/hold", bad_ord, 0);
    check(bad_rdy == 0, "R4 ready during load", bad_rdy, 0);
    if (stop_after == 0) begin
      check(beats == exp_beats, req, beats, exp_beats);
      check(win_ready && !fetch_req, "R4 ready after load", int'(win_ready), 1);
    end
  endtask

  task automatic read_window(input string req);
    int bad = 0, first_act = 0, first_exp = 0;
    for (int x = 0; x < W; x++) begin
      for (int y = 0; y < W; y++) begin
        @(negedge clk);
        if (x + y > 0) begin
          int px = (y == 0) ? x - 1 : x;
          int py = (y == 0) ? W - 1 : y - 1;
          if (rd_pix != ref_pix(row_id, base + px, py)) begin
            if (bad == 0) begin
              first_act = int'(rd_pix);
              first_exp = int'(ref_pix(row_id, base + px, py));
            end
            bad++;
          end
        end
        rd_x = XW'(x); rd_y = XW'(y);
      end
    end
    @(negedge clk);
    if (rd_pix != ref_pix(row_id, base + W - 1, W - 1)) begin
      if (bad == 0) begin
        first_act = int'(rd_pix);
        first_exp = int'(ref_pix(row_id, base + W - 1, W - 1));
      end
      bad++;
    end
    check(bad == 0, req, first_act, first_exp);
  endtask

  initial begin
    void'($urandom(32'h5EA4C11));
    repeat (3) @(negedge clk);
    check(!win_ready && !fetch_req, "R1", int'(win_ready) + int'(fetch_req), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!win_ready && !fetch_req, "R1 after release", int'(fetch_req), 0);

    // R6: advance before any load is dropped
    @(negedge clk); blk_next = 1'b1;
    @(negedge clk); blk_next = 1'b0;
    repeat (2) @(negedge clk);
    check(!fetch_req && !win_ready, "R6 early advance", int'(fetch_req), 0);

    // R2 full load, R5 read
    row_id = 1;
    pulse_row();
    serve(W * W, 0, 0, "R2 full load beats");
    read_window("R5 first window");

    // R3 advance with R6 injection during the load
    pulse_blk();
    inject_adv = 1'b1;
    serve(N * W, W - N, 0, "R3/R6 advance beats");
    inject_adv = 1'b0;
    read_window("R5 second window");

    // R7 restart mid-load
    pulse_blk();
    serve(0, W - N, 5, "R7");
    row_id = 2;
    pulse_row();
    serve(W * W, 0, 0, "R7 restart full beats");
    read_window("R7 window after restart");

    // R9 wrap: many advances in this row
    for (int b = 0; b < 7; b++) begin
      pulse_blk();
      serve(N * W, W - N, 0, "R3 advance beats");
      read_window("R9 wrapped window");
    end

    // Random rows
    for (int r = 0; r < 3; r++) begin
      int nb = 2 + int'($urandom % 5);
      row_id = 10 + r;
      pulse_row();
      serve(W * W, 0, 0, "R2 random row load");
      read_window("R5 random row");
      for (int b = 0; b < nb; b++) begin
        pulse_blk();
        serve(N * W, W - N, 0, "R3 random advance");
        read_window("R9 random advance window");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule